// File: doc/BRIEF.md
# Reset-Cause Status and Control Register

This block holds one 8-bit status and control byte for a small processor core. It records which reset source fired last: a power-on or low-voltage reset, or a watchdog reset. It also records a long-lasting bus condition, mirrors the global interrupt enable, and drives the suspend and run levels that gate the core. The power-on reset loads the whole byte. A watchdog reset reloads most bits but keeps the low-voltage flag and the bus-event flag, so firmware can tell the two reset causes apart after either one.

Firmware sees the byte on `status_q` at all times and writes it through a single-cycle write strobe. The sticky cause flags clear only when firmware writes a zero to them. Suspend is entered by writing a one and is left by hardware when a wake request arrives. The interrupt-enable mirror and the run bit change only through their dedicated strobes.

A built-in free-running tick, one every `TICK_CYCLES` clocks, stands for the 128 µs time base. The bus condition must stay present across two tick edges before the event flag is set, which gives a 128–256 µs window.

Top module: `rst_cause_ctrl`

## Requirements
- R1: While `por_lvr` is high, and after it falls, the byte reads 8'h11: bit 4 (low-voltage flag) and bit 0 (run) are 1 and every other bit is 0.
- R2: A one-cycle `wdog_rst` pulse takes effect at the next clock edge. It sets bit 6 (watchdog flag) and bit 0, clears bits 7, 3 and 2, and leaves bits 5 and 4 unchanged. This holds even while the core is halted or suspended.
- R3: A watchdog reset never changes bit 4, so a watchdog reset that follows a power-on reset reads 8'h51.
- R4: Bit 5 (bus event) is set at the clock edge of the second tick edge seen with `bus_cond` high without a break. A clock with `bus_cond` low restarts the count. A condition that lasts fewer than `TICK_CYCLES` clocks never sets it.
- R5: Bit 5 is set whether or not bit 2 is set. Only a firmware write of 0 to bit 5 or `por_lvr` clears it; a watchdog reset does not.
- R6: A firmware write (`fw_wr` high, data on `fw_wdata`) with a 0 in bit 6, 5 or 4 clears that bit at the next edge. A 1 written to those bits leaves them unchanged.
- R7: A firmware write with bit 3 = 1 sets bit 3 and raises `suspend` at the next edge. A write of 0 to bit 3 has no effect.
- R8: While bit 3 is set, a high `wake_req` clears it at the next edge. If `wake_req` is already high when bit 3 is written to 1, bit 3 reads 1 for exactly one cycle and is then cleared.
- R9: Bit 2 is set by `int_en` or `int_ret` and cleared by `int_dis`; `int_dis` wins if strobes coincide. Firmware writes to bit 2 have no effect.
- R10: Bit 1 always reads 0 and firmware writes to it have no effect.
- R11: `halt` clears bit 0 and drops `run` at the next edge. Only a watchdog reset or `por_lvr` sets bit 0 again. Firmware writes to bit 0 have no effect.
- R12: Bit 7 shows `irq_pend` from the previous clock. It reads 0 in the cycle after a watchdog reset, and firmware writes to bit 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_lvr | input | 1 | Power-on / low-voltage reset, active high, asynchronous |
| wdog_rst | input | 1 | Watchdog reset pulse, synchronous |
| bus_cond | input | 1 | Monitored bus condition level |
| wake_req | input | 1 | Wake request that ends suspend |
| irq_pend | input | 1 | Some interrupt is pending |
| int_en | input | 1 | Enable-interrupts strobe |
| int_dis | input | 1 | Disable-interrupts strobe |
| int_ret | input | 1 | Return-from-interrupt strobe |
| halt | input | 1 | Halt strobe |
| fw_wr | input | 1 | Firmware write strobe |
| fw_wdata | input | 8 | Firmware write data |
| status_q | output | 8 | Register value as firmware reads it |
| suspend | output | 1 | Suspend level to the core |
| run | output | 1 | Run level to the core |

## Verification
Every synchronous input except the bus condition shows up in `status_q` exactly one clock edge after it is driven. The bench drives each stimulus on a falling edge, lets one rising edge pass and reads the byte on the next falling edge. The asynchronous power-on reset is read back as soon as it is released. The bus event depends on the tick phase, which the bench does not track. So the bench holds the condition either for fewer than `TICK_CYCLES` clocks, where two tick edges cannot occur, or for at least `2*TICK_CYCLES+1` clocks, where two must occur, and checks the flag only after the window closes. The suspend case with a wake request already present is read on two consecutive falling edges, expecting 1 and then 0.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int unsigned BIT_IPEND = 7;
  localparam int unsigned BIT_WDOG  = 6;
  localparam int unsigned BIT_BUSEV = 5;
  localparam int unsigned BIT_LOWV  = 4;
  localparam int unsigned BIT_SUSP  = 3;
  localparam int unsigned BIT_IEN   = 2;
  localparam int unsigned BIT_RSVD  = 1;
  localparam int unsigned BIT_RUN   = 0;

  localparam logic [7:0] POR_VALUE = 8'h11;

  // Sticky flag update: hardware set wins over a firmware write-zero clear.
  function automatic logic sticky_next(input logic cur, input logic hw_set,
                                       input logic wr, input logic wbit);
    if (hw_set)          return 1'b1;
    else if (wr && !wbit) return 1'b0;
    else                 return cur;
  endfunction

  // Interrupt-enable mirror: disable wins over enable or return.
  function automatic logic ien_next(input logic cur, input logic en,
                                    input logic dis, input logic ret);
    if (dis)            return 1'b0;
    else if (en || ret) return 1'b1;
    else                return cur;
  endfunction

  // Byte seen by firmware, built from the individual state bits.
  function automatic logic [7:0] pack_status(input logic ipend, input logic wdog,
                                             input logic busev, input logic lowv,
                                             input logic susp, input logic ien,
                                             input logic runb);
    return {ipend, wdog, busev, lowv, susp, ien, 1'b0, runb};
  endfunction
endpackage

// File: rtl/rcs_tick_gen.sv
module rcs_tick_gen #(
  parameter int unsigned TICK_CYCLES = 16
) (
  input  logic clk,
  input  logic por_lvr,
  output logic tick
);
  localparam int unsigned CW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or posedge por_lvr) begin
    if (por_lvr)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);

  a_r4_tick_spacing: assert property (@(posedge clk) disable iff (por_lvr)
    tick |=> !tick);
endmodule

// File: rtl/rcs_bus_event_det.sv
module rcs_bus_event_det #(
  parameter int unsigned HOLD_TICKS = 2
) (
  input  logic clk,
  input  logic por_lvr,
  input  logic wdog_rst,
  input  logic tick,
  input  logic bus_cond,
  output logic fire
);
  localparam int unsigned HW = $clog2(HOLD_TICKS + 1);
  localparam logic [HW-1:0] FULL = HW'(HOLD_TICKS);
  localparam logic [HW-1:0] ARM  = HW'(HOLD_TICKS - 1);

  logic [HW-1:0] seen_q;

  always_ff @(posedge clk or posedge por_lvr) begin
    if (por_lvr)                    seen_q <= '0;
    else if (wdog_rst || !bus_cond) seen_q <= '0;
    else if (tick && seen_q != FULL) seen_q <= seen_q + 1'b1;
  end

  // Fires once, on the tick edge that completes the hold window.
  assign fire = bus_cond && tick && !wdog_rst && (seen_q == ARM);

  a_r4_needs_history: assert property (@(posedge clk) disable iff (por_lvr)
    fire |-> $past(bus_cond));
  a_r4_break_restarts: assert property (@(posedge clk) disable iff (por_lvr)
    !bus_cond |=> !fire);
endmodule

// File: rtl/rcs_core_ctrl.sv
module rcs_core_ctrl (
  input  logic clk,
  input  logic por_lvr,
  input  logic wdog_rst,
  input  logic fw_wr,
  input  logic fw_susp,
  input  logic wake_req,
  input  logic int_en,
  input  logic int_dis,
  input  logic int_ret,
  input  logic halt,
  output logic susp_q,
  output logic ien_q,
  output logic run_q
);
  import rcs_pkg::*;

  logic wake_hit;
  assign wake_hit = susp_q && wake_req;

  always_ff @(posedge clk or posedge por_lvr) begin
    if (por_lvr) begin
      susp_q <= POR_VALUE[BIT_SUSP];
      ien_q  <= POR_VALUE[BIT_IEN];
      run_q  <= POR_VALUE[BIT_RUN];
    end else if (wdog_rst) begin
      susp_q <= 1'b0;
      ien_q  <= 1'b0;
      run_q  <= 1'b1;
    end else begin
      if (wake_hit)              susp_q <= 1'b0;
      else if (fw_wr && fw_susp) susp_q <= 1'b1;
      ien_q <= ien_next(ien_q, int_en, int_dis, int_ret);
      if (halt) run_q <= 1'b0;
    end
  end

  a_r8_wake_clears: assert property (@(posedge clk) disable iff (por_lvr)
    susp_q && wake_req |=> !susp_q);
  a_r7_enter: assert property (@(posedge clk) disable iff (por_lvr)
    fw_wr && fw_susp && !susp_q && !wdog_rst |=> susp_q);
  a_r11_halt: assert property (@(posedge clk) disable iff (por_lvr)
    halt && !wdog_rst |=> !run_q);
  a_r11_run_source: assert property (@(posedge clk) disable iff (por_lvr)
    $rose(run_q) |-> $past(wdog_rst));
  a_r9_dis_wins: assert property (@(posedge clk) disable iff (por_lvr)
    int_dis |=> !ien_q);
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl #(
  parameter int unsigned TICK_CYCLES = 16,
  parameter int unsigned HOLD_TICKS  = 2
) (
  input  logic       clk,
  input  logic       por_lvr,
  input  logic       wdog_rst,
  input  logic       bus_cond,
  input  logic       wake_req,
  input  logic       irq_pend,
  input  logic       int_en,
  input  logic       int_dis,
  input  logic       int_ret,
  input  logic       halt,
  input  logic       fw_wr,
  input  logic [7:0] fw_wdata,
  output logic [7:0] status_q,
  output logic       suspend,
  output logic       run
);
  import rcs_pkg::*;

  logic tick;
  logic busev_fire;
  logic susp_q, ien_q, run_q;
  logic ipend_q, wdog_q, busev_q, lowv_q;
  logic fw_ignored;

  rcs_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk(clk), .por_lvr(por_lvr), .tick(tick));

  rcs_bus_event_det #(.HOLD_TICKS(HOLD_TICKS)) u_busdet (
    .clk(clk), .por_lvr(por_lvr), .wdog_rst(wdog_rst), .tick(tick),
    .bus_cond(bus_cond), .fire(busev_fire));

  rcs_core_ctrl u_core (
    .clk(clk), .por_lvr(por_lvr), .wdog_rst(wdog_rst), .fw_wr(fw_wr),
    .fw_susp(fw_wdata[BIT_SUSP]), .wake_req(wake_req), .int_en(int_en),
    .int_dis(int_dis), .int_ret(int_ret), .halt(halt),
    .susp_q(susp_q), .ien_q(ien_q), .run_q(run_q));

  always_ff @(posedge clk or posedge por_lvr) begin
    if (por_lvr) begin
      ipend_q <= POR_VALUE[BIT_IPEND];
      wdog_q  <= POR_VALUE[BIT_WDOG];
      busev_q <= POR_VALUE[BIT_BUSEV];
      lowv_q  <= POR_VALUE[BIT_LOWV];
    end else if (wdog_rst) begin
      ipend_q <= 1'b0;
      wdog_q  <= 1'b1;
    end else begin
      ipend_q <= irq_pend;
      wdog_q  <= sticky_next(wdog_q,  1'b0,       fw_wr, fw_wdata[BIT_WDOG]);
      busev_q <= sticky_next(busev_q, busev_fire, fw_wr, fw_wdata[BIT_BUSEV]);
      lowv_q  <= sticky_next(lowv_q,  1'b0,       fw_wr, fw_wdata[BIT_LOWV]);
    end
  end

  assign status_q = pack_status(ipend_q, wdog_q, busev_q, lowv_q, susp_q, ien_q, run_q);
  assign suspend  = susp_q;
  assign run      = run_q;

  // Write-data bits that have no firmware effect, brought out for checking.
  assign fw_ignored = fw_wr && |{fw_wdata[BIT_IPEND], fw_wdata[BIT_IEN],
                                 fw_wdata[BIT_RSVD], fw_wdata[BIT_RUN]};

  a_r2_wdog_load: assert property (@(posedge clk) disable iff (por_lvr)
    wdog_rst |=> status_q[BIT_WDOG] && run && !suspend && !status_q[BIT_IEN]
                 && !status_q[BIT_IPEND]);
  a_r3_lowv_kept: assert property (@(posedge clk) disable iff (por_lvr)
    wdog_rst |=> status_q[BIT_LOWV] == $past(status_q[BIT_LOWV]));
  a_r5_busev_kept: assert property (@(posedge clk) disable iff (por_lvr)
    wdog_rst |=> status_q[BIT_BUSEV] == $past(status_q[BIT_BUSEV]));
  a_r4_fire_sets: assert property (@(posedge clk) disable iff (por_lvr)
    busev_fire |=> status_q[BIT_BUSEV]);
  a_r6_write_one_keeps: assert property (@(posedge clk) disable iff (por_lvr)
    fw_wr && fw_wdata[BIT_WDOG] && !wdog_rst |=>
      status_q[BIT_WDOG] == $past(status_q[BIT_WDOG]));
  a_r10_ignored_bits: assert property (@(posedge clk) disable iff (por_lvr)
    fw_ignored && !int_en && !int_dis && !int_ret && !halt && !wdog_rst |=>
      status_q[BIT_IEN] == $past(status_q[BIT_IEN]) && run == $past(run)
      && status_q[BIT_IPEND] == $past(irq_pend) && !status_q[BIT_RSVD]);
  a_r12_pend_follow: assert property (@(posedge clk) disable iff (por_lvr)
    !wdog_rst |=> status_q[BIT_IPEND] == $past(irq_pend));
endmodule

// File: tb/rst_cause_ctrl_test.sv
module rst_cause_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICKS = 16;

  logic clk = 1'b0;
  logic por_lvr = 1'b0, wdog_rst = 1'b0, bus_cond = 1'b0, wake_req = 1'b0;
  logic irq_pend = 1'b0, int_en = 1'b0, int_dis = 1'b0, int_ret = 1'b0;
  logic halt = 1'b0, fw_wr = 1'b0;
  logic [7:0] fw_wdata = 8'h00;
  logic [7:0] status_q;
  logic suspend, run;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_cause_ctrl #(.TICK_CYCLES(TICKS), .HOLD_TICKS(2)) uut (
    .clk(clk), .por_lvr(por_lvr), .wdog_rst(wdog_rst), .bus_cond(bus_cond),
    .wake_req(wake_req), .irq_pend(irq_pend), .int_en(int_en), .int_dis(int_dis),
    .int_ret(int_ret), .halt(halt), .fw_wr(fw_wr), .fw_wdata(fw_wdata),
    .status_q(status_q), .suspend(suspend), .run(run));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic do_por();
    @(negedge clk); por_lvr = 1'b1;
    @(negedge clk); por_lvr = 1'b0;
  endtask

  task automatic fw_write(input logic [7:0] d);
    fw_wr = 1'b1; fw_wdata = d; step(); fw_wr = 1'b0; fw_wdata = 8'h00;
  endtask

  task automatic pulse_wdog(); wdog_rst = 1'b1; step(); wdog_rst = 1'b0; endtask

  task automatic t_por();
    do_por();
    check("R1 por value", status_q, 8'h11);
    check("R1 run/suspend", {6'd0, run, suspend}, 8'h02);
  endtask

  task automatic t_ignored_writes();
    fw_write(8'hF6);
    check("R10 R9 R6 ignored/one-writes", status_q, 8'h11);
  endtask

  task automatic t_ien();
    int_en = 1'b1; step(); int_en = 1'b0;
    check("R9 enable", status_q, 8'h15);
    int_dis = 1'b1; step(); int_dis = 1'b0;
    check("R9 disable", status_q, 8'h11);
    int_ret = 1'b1; step(); int_ret = 1'b0;
    check("R9 return", status_q, 8'h15);
    fw_write(8'hF0);
    check("R9 write zero ignored", status_q, 8'h15);
    int_en = 1'b1; int_dis = 1'b1; step(); int_en = 1'b0; int_dis = 1'b0;
    check("R9 disable wins", status_q, 8'h11);
  endtask

  task automatic t_pending();
    irq_pend = 1'b1; step();
    check("R12 pending shown", status_q, 8'h91);
    fw_write(8'h70);
    check("R12 write ignored", status_q, 8'h91);
    irq_pend = 1'b0; step();
    check("R12 pending drops", status_q, 8'h11);
  endtask

  task automatic t_halt_wdog();
    halt = 1'b1; step(); halt = 1'b0;
    check("R11 halt", status_q, 8'h10);
    fw_write(8'hF1);
    check("R11 write ignored", status_q, 8'h10);
    pulse_wdog();
    check("R2 R3 wdog after por", status_q, 8'h51);
  endtask

  task automatic t_fw_clear();
    fw_write(8'hB7);
    check("R6 clear bit6", status_q, 8'h11);
    fw_write(8'hE7);
    check("R6 clear bit4", status_q, 8'h01);
  endtask

  task automatic hold_cond(input int n);
    bus_cond = 1'b1; repeat (n) step(); bus_cond = 1'b0; step();
  endtask

  task automatic t_bus_event();
    hold_cond(TICKS - 1);
    check("R4 short condition", status_q, 8'h01);
    for (int i = 0; i < 4; i++) hold_cond(TICKS - 1);
    check("R4 broken condition", status_q, 8'h01);
    hold_cond(2*TICKS + 1);
    check("R4 R5 long condition, ints off", status_q, 8'h21);
    pulse_wdog();
    check("R5 R2 wdog keeps bus event", status_q, 8'h61);
    fw_write(8'hD7);
    check("R5 R6 fw clears bus event", status_q, 8'h41);
    hold_cond(2*TICKS + 1);
    check("R4 set again", status_q, 8'h61);
    do_por();
    check("R5 R1 por clears", status_q, 8'h11);
  endtask

  task automatic t_suspend();
    fw_write(8'hF8);
    check("R7 enter", status_q, 8'h19);
    check("R7 suspend pin", {7'd0, suspend}, 8'h01);
    repeat (3) step();
    check("R7 stays", status_q, 8'h19);
    fw_write(8'hF0);
    check("R7 zero write no effect", status_q, 8'h19);
    wake_req = 1'b1; step(); wake_req = 1'b0;
    check("R8 wake clears", status_q, 8'h11);
    wake_req = 1'b1; fw_write(8'hF8);
    check("R8 entered with wake present", status_q, 8'h19);
    step(); wake_req = 1'b0;
    check("R8 then cleared", status_q, 8'h11);
    fw_write(8'hF8);
    irq_pend = 1'b1; pulse_wdog();
    check("R2 R12 wdog in suspend", status_q, 8'h51);
    step(); irq_pend = 1'b0;
    check("R12 pending after wdog", status_q, 8'hD1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog timeout actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    por_lvr = 1'b1;
    repeat (2) @(negedge clk);
    por_lvr = 1'b0;
    t_por();
    t_ignored_writes();
    t_ien();
    t_pending();
    t_halt_wdog();
    t_fw_clear();
    t_bus_event();
    t_suspend();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule